// File: doc/BRIEF.md
# 100BASE-TX Receive Code-Group Decoder

This block sits behind a code-group aligner on the 100 Mb/s receive path. On every clock where the aligner's strobe is high, it takes one 5-bit code group and produces the MII-style receive signals: a 4-bit nibble, a data-valid flag, an error flag and carrier sense. It recognises the two-symbol delimiters that open and close a stream, converts data code groups to nibbles with the 4B/5B mapping, marks bad symbols, and closes a stream that falls back to idle without a proper end delimiter.

Each delimiter is defined by a pair of symbols, so the decoder holds back one code group. The registered outputs after a strobe describe the group received on the previous strobe, and the decision uses the group that has just arrived. The controller has four states. `S_IDLE` waits for a J followed by a K. `S_SSD2` emits the second preamble nibble, the one that stands for K. `S_DATA` carries the frame body. `S_ESD2` emits the R slot of the end delimiter. The transitions are: `S_IDLE -> S_SSD2` on the pair J,K. `S_SSD2 -> S_DATA` on the next strobe. `S_DATA -> S_ESD2` on the pair T,R. `S_DATA -> S_IDLE` on a held-back IDLE (early end). `S_ESD2 -> S_IDLE` on the next strobe. Every other case keeps the state. A synchronous reset returns the block to `S_IDLE`.

Top module: `rxdec_top`

## Requirements
- R1: While `rst` is high on a clock edge, the block goes to idle with `rxd`=0000 and `rx_dv`, `rx_er` and `crs` low after that edge. The held-back code group is reset to IDLE (11111).
- R2: A J (11000) on one strobe followed by a K (10001) on the next raises `crs` and `rx_dv` with `rxd`=0101 after the K strobe. The following strobe again shows 0101 with `rx_dv` high. Each output reflects the code group of the previous strobe.
- R3: A J that is not followed by K is a false carrier. `crs` and `rx_dv` stay low and `rx_er` stays low.
- R4: Inside a stream, each data code group is output one strobe later as its nibble, with `rx_dv` and `crs` high and `rx_er` low. The mapping, nibble 0 to F, is: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A T (01101) followed by an R (00111) ends the stream. The output slot for T has `rx_dv` low and `crs` still high. The slot for R has `crs` low. Neither slot has a valid nibble, and `rxd` is 0000 in both.
- R6: An IDLE group held back while in a stream drops `crs` and `rx_dv` in its slot. `rx_er` is high for exactly that one clock.
- R7: Inside a stream, any code group that is neither data nor the start of a T,R pair produces `rx_er` high with `rxd`=1110, while `rx_dv` and `crs` stay high. This covers H (00100), a stray J, K or R, a T not followed by R, and unused codes.
- R8: On a clock with `cg_valid` low, `rxd`, `rx_dv` and `crs` hold their values and no state advances. An early-end error pulse (R6) still clears after its one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_valid | input | 1 | Strobe from the aligner: `cg_in` holds a new code group |
| cg_in | input | 5 | Aligned 5-bit code group |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock and that `cg_in` is known whenever `cg_valid` is high. They make no assumption about the order of code groups, so the stimulus is free to send stray delimiters, repeated J symbols, a T without R, and frames placed back to back. The stimulus drives at the falling edge and holds every code group for exactly one clock. Strobe gaps are placed both inside a frame and directly after an early-end error, which exercises the one-clock pulse rule together with the hold rule.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SSD2,
        S_DATA,
        S_ESD2
    } rx_state_e;

    typedef enum logic [2:0] {
        G_DATA,
        G_IDLE,
        G_J,
        G_K,
        G_T,
        G_R,
        G_BAD
    } cg_kind_e;

    localparam logic [CG_W-1:0]  CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0]  CG_J    = 5'b11000;
    localparam logic [CG_W-1:0]  CG_K    = 5'b10001;
    localparam logic [CG_W-1:0]  CG_T    = 5'b01101;
    localparam logic [CG_W-1:0]  CG_R    = 5'b00111;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_ERR  = 4'b1110;
    localparam logic [NIB_W-1:0] NIB_ZERO = 4'b0000;

endpackage

// File: rtl/rxdec_classify.sv
module rxdec_classify
    import rxdec_pkg::*;
(
    input  logic [CG_W-1:0]  cg,
    output cg_kind_e         kind,
    output logic [NIB_W-1:0] nib
);

    always_comb begin
        kind = G_DATA;
        nib  = NIB_ZERO;
        unique case (cg)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            CG_IDLE:  kind = G_IDLE;
            CG_J:     kind = G_J;
            CG_K:     kind = G_K;
            CG_T:     kind = G_T;
            CG_R:     kind = G_R;
            default:  kind = G_BAD;
        endcase
    end

endmodule

// File: rtl/rxdec_lookahead.sv
module rxdec_lookahead
    import rxdec_pkg::*;
#(
    parameter int W = CG_W,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (adv) begin
            q <= d;
        end
    end

endmodule

// File: rtl/rxdec_fsm.sv
module rxdec_fsm
    import rxdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  cg_kind_e         prev_kind,
    input  logic [NIB_W-1:0] prev_nib,
    input  cg_kind_e         cur_kind,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs
);

    rx_state_e        state_q;
    rx_state_e        state_d;
    logic [NIB_W-1:0] rxd_d;
    logic             dv_d;
    logic             er_d;
    logic             crs_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else if (adv) begin
            state_q <= state_d;
        end
    end

    // next state and next outputs for the held-back group
    always_comb begin
        state_d = state_q;
        rxd_d   = NIB_ZERO;
        dv_d    = 1'b0;
        er_d    = 1'b0;
        crs_d   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (prev_kind == G_J && cur_kind == G_K) begin
                    state_d = S_SSD2;
                    rxd_d   = NIB_PRE;
                    dv_d    = 1'b1;
                    crs_d   = 1'b1;
                end
            end
            S_SSD2: begin
                state_d = S_DATA;
                rxd_d   = NIB_PRE;
                dv_d    = 1'b1;
                crs_d   = 1'b1;
            end
            S_DATA: begin
                if (prev_kind == G_T && cur_kind == G_R) begin
                    state_d = S_ESD2;
                    crs_d   = 1'b1;
                end else if (prev_kind == G_IDLE) begin
                    state_d = S_IDLE;
                    er_d    = 1'b1;
                end else if (prev_kind == G_DATA) begin
                    rxd_d   = prev_nib;
                    dv_d    = 1'b1;
                    crs_d   = 1'b1;
                end else begin
                    rxd_d   = NIB_ERR;
                    dv_d    = 1'b1;
                    er_d    = 1'b1;
                    crs_d   = 1'b1;
                end
            end
            S_ESD2: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rxd   <= NIB_ZERO;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
            crs   <= 1'b0;
        end else if (adv) begin
            rxd   <= rxd_d;
            rx_dv <= dv_d;
            rx_er <= er_d;
            crs   <= crs_d;
        end else if (state_q == S_IDLE) begin
            rx_er <= 1'b0;
        end
    end

endmodule

// File: rtl/rxdec_top.sv
module rxdec_top
    import rxdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cg_valid,
    input  logic [CG_W-1:0]  cg_in,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             crs
);

    logic [CG_W-1:0]  prev_cg;
    cg_kind_e         prev_kind;
    cg_kind_e         cur_kind;
    logic [NIB_W-1:0] prev_nib;
    logic [NIB_W-1:0] cur_nib_unused;

    rxdec_lookahead #(.W(CG_W), .RST_VAL(CG_IDLE)) hold_i (
        .clk (clk),
        .rst (rst),
        .adv (cg_valid),
        .d   (cg_in),
        .q   (prev_cg)
    );

    rxdec_classify prev_cls_i (
        .cg   (prev_cg),
        .kind (prev_kind),
        .nib  (prev_nib)
    );

    rxdec_classify cur_cls_i (
        .cg   (cg_in),
        .kind (cur_kind),
        .nib  (cur_nib_unused)
    );

    rxdec_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .adv       (cg_valid),
        .prev_kind (prev_kind),
        .prev_nib  (prev_nib),
        .cur_kind  (cur_kind),
        .rxd       (rxd),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .crs       (crs)
    );

endmodule

// File: rtl/rxdec_chk.sv
module rxdec_chk
    import rxdec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cg_valid,
    input logic [CG_W-1:0]  cg_in,
    input logic [NIB_W-1:0] rxd,
    input logic             rx_dv,
    input logic             rx_er,
    input logic             crs
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!crs && !rx_dv && !rx_er && rxd == NIB_ZERO));

    assert_dv_needs_crs_R2: assert property (@(posedge clk) disable iff (rst)
        rx_dv |-> crs);

    assert_sof_preamble_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(crs) |-> (rx_dv && !rx_er && rxd == NIB_PRE));

    assert_crs_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(crs) |-> !rx_dv);

    assert_early_idle_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !rx_dv) |=> !rx_er);

    assert_early_idle_crs_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !rx_dv) |-> !crs);

    assert_err_nibble_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_er && rx_dv) |-> (rxd == NIB_ERR && crs));

    assert_hold_gap_R8: assert property (@(posedge clk) disable iff (rst)
        !cg_valid |=> ($stable(rxd) && $stable(rx_dv) && $stable(crs)));

    assert_known_input: assert property (@(posedge clk) disable iff (rst)
        cg_valid |-> !$isunknown(cg_in));

endmodule

bind rxdec_top rxdec_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cg_valid (cg_valid),
    .cg_in    (cg_in),
    .rxd      (rxd),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .crs      (crs)
);

// File: tb/rxdec_top_tb_top.sv
module rxdec_top_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] S_IDL = 5'b11111;
    localparam logic [4:0] S_J   = 5'b11000;
    localparam logic [4:0] S_K   = 5'b10001;
    localparam logic [4:0] S_T   = 5'b01101;
    localparam logic [4:0] S_R   = 5'b00111;
    localparam logic [4:0] S_H   = 5'b00100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cg_valid = 1'b1;
    logic [4:0] cg_in = 5'b11111;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;
    logic       crs;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [4:0] code_tab[16];
    logic [4:0] m_prev = 5'b11111;
    int         m_mode = 0;   // 0 idle, 1 second preamble, 2 body, 3 end slot
    logic [3:0] e_rxd = 4'd0;
    logic       e_dv = 1'b0, e_er = 1'b0, e_crs = 1'b0;
    string      cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdec_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .cg_valid (cg_valid),
        .cg_in    (cg_in),
        .rxd      (rxd),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .crs      (crs)
    );

    function automatic int data_of(input logic [4:0] c);
        for (int i = 0; i < 16; i++) if (code_tab[i] == c) return i;
        return -1;
    endfunction

    function automatic logic [4:0] dc(input int n);
        return code_tab[n];
    endfunction

    task automatic compare();
        n_checks++;
        if (rxd !== e_rxd || rx_dv !== e_dv || rx_er !== e_er || crs !== e_crs) begin
            n_fail++;
            $display("FAIL %s: got rxd=%b dv=%b er=%b crs=%b expected rxd=%b dv=%b er=%b crs=%b",
                     cur_tag, rxd, rx_dv, rx_er, crs, e_rxd, e_dv, e_er, e_crs);
        end
    endtask

    task automatic model_edge(input logic r, input logic v, input logic [4:0] c);
        int d;
        if (r) begin
            m_prev = S_IDL; m_mode = 0;
            e_rxd = 4'd0; e_dv = 0; e_er = 0; e_crs = 0;
            return;
        end
        if (!v) begin
            if (m_mode == 0) e_er = 0;
            return;
        end
        e_rxd = 4'd0; e_dv = 0; e_er = 0; e_crs = 0;
        d = data_of(m_prev);
        if (m_mode == 0) begin
            if (m_prev == S_J && c == S_K) begin
                e_rxd = 4'b0101; e_dv = 1; e_crs = 1; m_mode = 1;
            end
        end else if (m_mode == 1) begin
            e_rxd = 4'b0101; e_dv = 1; e_crs = 1; m_mode = 2;
        end else if (m_mode == 2) begin
            if (m_prev == S_T && c == S_R) begin
                e_crs = 1; m_mode = 3;
            end else if (m_prev == S_IDL) begin
                e_er = 1; m_mode = 0;
            end else if (d >= 0) begin
                e_rxd = 4'(d); e_dv = 1; e_crs = 1;
            end else begin
                e_rxd = 4'b1110; e_dv = 1; e_er = 1; e_crs = 1;
            end
        end else begin
            m_mode = 0;
        end
        m_prev = c;
    endtask

    // check the outputs of the previous edge, then drive the next inputs
    task automatic step(input logic r, input logic v, input logic [4:0] c, input string tag);
        @(negedge clk);
        compare();
        rst = r; cg_valid = v; cg_in = c; cur_tag = tag;
        model_edge(r, v, c);
    endtask

    task automatic sym(input logic [4:0] c, input string tag);
        step(1'b0, 1'b1, c, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            case (i)
                0: code_tab[i] = 5'b11110;  1: code_tab[i] = 5'b01001;
                2: code_tab[i] = 5'b10100;  3: code_tab[i] = 5'b10101;
                4: code_tab[i] = 5'b01010;  5: code_tab[i] = 5'b01011;
                6: code_tab[i] = 5'b01110;  7: code_tab[i] = 5'b01111;
                8: code_tab[i] = 5'b10010;  9: code_tab[i] = 5'b10011;
                10: code_tab[i] = 5'b10110; 11: code_tab[i] = 5'b10111;
                12: code_tab[i] = 5'b11010; 13: code_tab[i] = 5'b11011;
                14: code_tab[i] = 5'b11100; default: code_tab[i] = 5'b11101;
            endcase
        end
        // R1: reset
        model_edge(1'b1, 1'b1, S_IDL);
        step(1'b1, 1'b1, S_IDL, "R1");
        step(1'b1, 1'b1, S_IDL, "R1");
        for (int i = 0; i < 3; i++) sym(S_IDL, "R1");

        // R2 / R4 / R5: full frame with every data nibble
        sym(S_J, "R2"); sym(S_K, "R2");
        for (int i = 0; i < 6; i++) sym(dc(5), "R4");
        sym(dc(13), "R4");
        for (int i = 0; i < 16; i++) sym(dc(i), "R4");
        sym(S_T, "R5"); sym(S_R, "R5");
        sym(S_IDL, "R5"); sym(S_IDL, "R5");

        // R3: false carrier
        sym(S_J, "R3"); sym(S_IDL, "R3"); sym(S_IDL, "R3");
        sym(S_J, "R3"); sym(dc(0), "R3"); sym(S_IDL, "R3");
        sym(S_J, "R3"); sym(S_H, "R3"); sym(S_IDL, "R3");

        // R7: repeated J before K, then bad groups in the body
        sym(S_J, "R2"); sym(S_J, "R2"); sym(S_K, "R2");
        sym(dc(5), "R4"); sym(dc(10), "R4");
        sym(S_H, "R7"); sym(dc(3), "R7");
        sym(S_R, "R7"); sym(S_J, "R7"); sym(S_K, "R7");
        sym(5'b00000, "R7"); sym(dc(7), "R7");
        sym(S_T, "R7"); sym(dc(1), "R7");
        sym(S_T, "R5"); sym(S_R, "R5"); sym(S_IDL, "R5");

        // R8: gaps inside a frame
        sym(S_J, "R2"); sym(S_K, "R2"); sym(dc(9), "R4");
        step(1'b0, 1'b0, S_H, "R8"); step(1'b0, 1'b0, S_IDL, "R8");
        step(1'b0, 1'b0, dc(2), "R8");
        sym(dc(4), "R8"); sym(dc(6), "R8");
        sym(S_T, "R5"); sym(S_R, "R5");
        // back-to-back frame
        sym(S_J, "R2"); sym(S_K, "R2"); sym(dc(8), "R4");
        sym(S_T, "R5"); sym(S_R, "R5"); sym(S_IDL, "R5");

        // R6: early idle, continuous strobes
        sym(S_J, "R6"); sym(S_K, "R6"); sym(dc(2), "R6"); sym(dc(11), "R6");
        sym(S_IDL, "R6"); sym(S_IDL, "R6"); sym(S_IDL, "R6"); sym(S_IDL, "R6");
        // R6 with R8: gap right after the error pulse
        sym(S_J, "R6"); sym(S_K, "R6"); sym(dc(12), "R6");
        sym(S_IDL, "R6"); sym(S_IDL, "R6");
        step(1'b0, 1'b0, S_IDL, "R8"); step(1'b0, 1'b0, S_IDL, "R8");
        sym(S_IDL, "R8"); sym(S_IDL, "R8");

        // R1: reset in the middle of a frame
        sym(S_J, "R1"); sym(S_K, "R1"); sym(dc(15), "R1");
        step(1'b1, 1'b1, dc(15), "R1");
        sym(dc(15), "R1"); sym(S_IDL, "R1"); sym(S_IDL, "R1");

        @(negedge clk);
        compare();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no finish, expected end of stimulus");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule